// File: doc/BRIEF.md
# Strided Tile Row Mover

This block moves one two-dimensional tile between a tile register file and a single-request memory port. A tile holds up to 16 rows of up to 64 bytes. The row count and the bytes per row come from configuration inputs, which are captured when a command is accepted. The command supplies only a direction, a tile index, a base address and a row stride.

Row r of the tile lives at `base + r*stride` in memory. The engine issues one memory request per row, in ascending row order, and waits for that row's response before it issues the next one. Loads unpack each returned row into the tile file. A load keeps only the configured number of bytes, zeroes the bytes above them, and then writes zero rows for every row beyond the configured count. Stores read each tile row and send it with the bytes beyond the configured width forced to zero. A streaming-load variant moves data exactly like a load, but it marks its requests as unlikely to be reused.

Top module: `tile_row_mover`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle. A command offered while a transfer runs is ignored: it produces no extra requests, no tile writes and no change to the running transfer.
- R2: For a transfer of N rows, the engine issues exactly N requests, one per row. The request for row r carries address `base + r*stride` modulo 2^32, rows go in ascending order, and no request is issued while the previous one still awaits its response.
- R3: The row count and bytes per row are sampled when the command is accepted and then held. Values above 16 rows or 64 bytes are treated as 16 and 64. `mem_req_len` carries the effective bytes per row.
- R4: On a load, each response writes tile row r in the same cycle. Byte i (bits 8i+7..8i) comes from `mem_rsp_rdata` when i is below the effective byte count, and is zero otherwise.
- R5: After the last memory row of a load, the rows from the effective count up to row 15 are written with zero, one per cycle in ascending order. A load of zero rows writes all 16 rows as zero and issues no request.
- R6: A store drives `mem_req_write`=1. Its request data is the addressed tile row with bytes at or above the effective byte count forced to zero. A store writes nothing into the tile file.
- R7: `cmd_op` bit 1 selects store (1) or load (0). Bit 0 selects the streaming variant for loads only. `mem_req_nt` is 1 on every request of a streaming load (op 1) and 0 for ops 0, 2 and 3.
- R8: `done` is a one-cycle pulse. It is due in the cycle after the final tile write of a load, or after the last response of a store. A store of zero rows pulses `done` in the cycle after acceptance.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, length, direction and hint are held.
- R10: During and right after reset the engine is idle: `cmd_ready`=1, and `mem_req_valid`, `tf_wr_en` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 2 | Bit 1 store, bit 0 streaming hint for loads |
| cmd_tile | input | 3 | Tile index in the tile file |
| cmd_base | input | 32 | Address of row 0 |
| cmd_stride | input | 32 | Address step between rows |
| cfg_rows | input | 5 | Configured row count |
| cfg_row_bytes | input | 7 | Configured bytes per row |
| mem_req_valid | output | 1 | Row request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_nt | output | 1 | Non-temporal hint |
| mem_req_addr | output | 32 | Row address |
| mem_req_len | output | 7 | Bytes in the row |
| mem_req_wdata | output | 512 | Store row data, byte i at bits 8i+7..8i |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_rdata | input | 512 | Load row data |
| tf_tile | output | 3 | Tile being transferred |
| tf_rd_row | output | 4 | Tile row read for a store |
| tf_rd_data | input | 512 | Tile row contents, same cycle |
| tf_wr_en | output | 1 | Tile row write |
| tf_wr_row | output | 4 | Tile row written |
| tf_wr_data | output | 512 | Tile row write data |
| done | output | 1 | Transfer finished pulse |

## Verification
The first request is due one cycle after acceptance. A load writes tile data in the same cycle as its response. Zero-fill writes follow in the cycles right after the last response, and `done` comes one cycle after the final write or response. The bench drives its inputs at the falling edge and compares 1 ns later. At that point it tracks which phase the transfer must be in from the handshakes it has seen, so every result is checked in the exact cycle it is due. The bench varies ready and response latency, and it keeps offering junk commands and configurations while a transfer is busy.

// File: rtl/tmv_pkg.sv
`timescale 1ns/1ps
package tmv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_RSP  = 3'd2,
    ST_ZERO = 3'd3,
    ST_FIN  = 3'd4
  } tmv_state_e;
endpackage

// File: rtl/tmv_addr_gen.sv
`timescale 1ns/1ps
module tmv_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d, stride_q, stride_d;

  // running address: row r reached by r additions of the stride
  always_comb begin
    addr_d   = addr_q;
    stride_d = stride_q;
    if (load) begin
      addr_d   = base;
      stride_d = stride;
    end else if (step) begin
      addr_d = addr_q + stride_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (load || step) begin
      addr_q   <= addr_d;
      stride_q <= stride_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/tmv_row_mask.sv
`timescale 1ns/1ps
module tmv_row_mask #(
  parameter int ROW_BYTES = 64,
  parameter int LEN_W     = $clog2(ROW_BYTES + 1)
) (
  input  logic [LEN_W-1:0]       len,
  input  logic [ROW_BYTES*8-1:0] din,
  output logic [ROW_BYTES*8-1:0] dout
);
  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
    assign dout[b*8 +: 8] = (LEN_W'(b) < len) ? din[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/tmv_ctrl.sv
`timescale 1ns/1ps
module tmv_ctrl
  import tmv_pkg::*;
#(
  parameter int MAX_ROWS = 16,
  parameter int ROW_W    = $clog2(MAX_ROWS),
  parameter int CNT_W    = $clog2(MAX_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [CNT_W-1:0] rows_in,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             cmd_ready,
  output logic             accept,
  output logic             req_valid,
  output logic             step,
  output logic             load_wr,
  output logic             zero_wr,
  output logic [ROW_W-1:0] row,
  output logic             store,
  output logic             hint,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST_ROW = CNT_W'(MAX_ROWS - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(MAX_ROWS);

  tmv_state_e       state_q, state_d;
  logic [CNT_W-1:0] row_q, row_d, rows_q, rows_d, row_inc;
  logic             store_q, store_d, hint_q, hint_d;
  logic             row_en, cfg_en;

  assign row_inc = row_q + CNT_W'(1);

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    rows_d  = rows_q;
    store_d = store_q;
    hint_d  = hint_q;
    row_en  = 1'b0;
    cfg_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          cfg_en  = 1'b1;
          row_en  = 1'b1;
          row_d   = '0;
          rows_d  = rows_in;
          store_d = cmd_op[1];
          hint_d  = cmd_op[0] & ~cmd_op[1];
          if (rows_in == '0) state_d = cmd_op[1] ? ST_FIN : ST_ZERO;
          else               state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (req_ready) state_d = ST_RSP;
      end
      ST_RSP: begin
        if (rsp_valid) begin
          row_en = 1'b1;
          row_d  = row_inc;
          if (row_inc == rows_q)
            state_d = (!store_q && rows_q != FULL) ? ST_ZERO : ST_FIN;
          else
            state_d = ST_REQ;
        end
      end
      ST_ZERO: begin
        row_en = 1'b1;
        row_d  = row_inc;
        if (row_q == LAST_ROW) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q  <= '0;
      store_q <= 1'b0;
      hint_q  <= 1'b0;
    end else if (cfg_en) begin
      rows_q  <= rows_d;
      store_q <= store_d;
      hint_q  <= hint_d;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_ready & cmd_valid;
  assign req_valid = (state_q == ST_REQ);
  assign step      = (state_q == ST_RSP) & rsp_valid;
  assign load_wr   = step & ~store_q;
  assign zero_wr   = (state_q == ST_ZERO);
  assign row       = row_q[ROW_W-1:0];
  assign store     = store_q;
  assign hint      = hint_q;
  assign done      = (state_q == ST_FIN);

  // R1: an accepted command closes the command port on the next cycle
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R8: completion is a single-cycle pulse followed by idle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
endmodule

// File: rtl/tile_row_mover.sv
`timescale 1ns/1ps
module tile_row_mover #(
  parameter int MAX_ROWS   = 16,
  parameter int ROW_BYTES  = 64,
  parameter int ADDR_W     = 32,
  parameter int TILE_IDX_W = 3,
  parameter int ROW_W      = $clog2(MAX_ROWS),
  parameter int CNT_W      = $clog2(MAX_ROWS + 1),
  parameter int LEN_W      = $clog2(ROW_BYTES + 1),
  parameter int DATA_W     = ROW_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [1:0]            cmd_op,
  input  logic [TILE_IDX_W-1:0] cmd_tile,
  input  logic [ADDR_W-1:0]     cmd_base,
  input  logic [ADDR_W-1:0]     cmd_stride,
  input  logic [CNT_W-1:0]      cfg_rows,
  input  logic [LEN_W-1:0]      cfg_row_bytes,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_write,
  output logic                  mem_req_nt,
  output logic [ADDR_W-1:0]     mem_req_addr,
  output logic [LEN_W-1:0]      mem_req_len,
  output logic [DATA_W-1:0]     mem_req_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [DATA_W-1:0]     mem_rsp_rdata,
  output logic [TILE_IDX_W-1:0] tf_tile,
  output logic [ROW_W-1:0]      tf_rd_row,
  input  logic [DATA_W-1:0]     tf_rd_data,
  output logic                  tf_wr_en,
  output logic [ROW_W-1:0]      tf_wr_row,
  output logic [DATA_W-1:0]     tf_wr_data,
  output logic                  done
);
  localparam logic [CNT_W-1:0] ROWS_CAP = CNT_W'(MAX_ROWS);
  localparam logic [LEN_W-1:0] LEN_CAP  = LEN_W'(ROW_BYTES);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [CNT_W-1:0]      rows_clamp;
  logic [LEN_W-1:0]      len_clamp, len_q, len_d;
  logic [TILE_IDX_W-1:0] tile_q, tile_d;
  logic                  accept, req_valid, step, load_wr, zero_wr, store, hint;
  logic [ROW_W-1:0]      row;
  logic [DATA_W-1:0]     rd_masked, wr_masked;

  assign rows_clamp = (cfg_rows > ROWS_CAP) ? ROWS_CAP : cfg_rows;
  assign len_clamp  = (cfg_row_bytes > LEN_CAP) ? LEN_CAP : cfg_row_bytes;

  always_comb begin
    tile_d = tile_q;
    len_d  = len_q;
    if (accept) begin
      tile_d = cmd_tile;
      len_d  = len_clamp;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tile_q <= '0;
      len_q  <= '0;
    end else if (accept) begin
      tile_q <= tile_d;
      len_q  <= len_d;
    end
  end

  tmv_ctrl #(.MAX_ROWS(MAX_ROWS), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rows_in   (rows_clamp),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .req_valid (req_valid),
    .step      (step),
    .load_wr   (load_wr),
    .zero_wr   (zero_wr),
    .row       (row),
    .store     (store),
    .hint      (hint),
    .done      (done)
  );

  tmv_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_ni),
    .load   (accept),
    .step   (step),
    .base   (cmd_base),
    .stride (cmd_stride),
    .addr   (mem_req_addr)
  );

  tmv_row_mask #(.ROW_BYTES(ROW_BYTES), .LEN_W(LEN_W)) u_mask_load (
    .len  (len_q),
    .din  (mem_rsp_rdata),
    .dout (rd_masked)
  );

  tmv_row_mask #(.ROW_BYTES(ROW_BYTES), .LEN_W(LEN_W)) u_mask_store (
    .len  (len_q),
    .din  (tf_rd_data),
    .dout (wr_masked)
  );

  assign mem_req_valid = req_valid;
  assign mem_req_write = store;
  assign mem_req_nt    = hint & req_valid;
  assign mem_req_len   = len_q;
  assign mem_req_wdata = wr_masked;
  assign tf_tile       = tile_q;
  assign tf_rd_row     = row;
  assign tf_wr_en      = load_wr | zero_wr;
  assign tf_wr_row     = row;
  assign tf_wr_data    = zero_wr ? '0 : rd_masked;

  // R9: a stalled request holds its fields
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_len) && $stable(mem_req_write) && $stable(mem_req_nt)));

  // R7: the hint appears only on read requests
  a_r7_hint_load: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req_nt |-> (mem_req_valid && !mem_req_write));

  // R5: tile writes not caused by a response are fill rows of zero
  a_r5_fill_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (tf_wr_en && !mem_rsp_valid) |-> (tf_wr_data == '0));
endmodule

// File: tb/tb_tile_row_mover.sv
`timescale 1ns/1ps
module tb_tile_row_mover;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, cmd_ready;
  logic [1:0]   cmd_op;
  logic [2:0]   cmd_tile;
  logic [31:0]  cmd_base, cmd_stride;
  logic [4:0]   cfg_rows;
  logic [6:0]   cfg_row_bytes;
  logic         mem_req_valid, mem_req_ready, mem_req_write, mem_req_nt;
  logic [31:0]  mem_req_addr;
  logic [6:0]   mem_req_len;
  logic [511:0] mem_req_wdata;
  logic         mem_rsp_valid;
  logic [511:0] mem_rsp_rdata;
  logic [2:0]   tf_tile;
  logic [3:0]   tf_rd_row, tf_wr_row;
  logic [511:0] tf_rd_data, tf_wr_data;
  logic         tf_wr_en, done;

  always #4 clk = ~clk;

  tile_row_mover dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_tile(cmd_tile), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
    .cfg_rows(cfg_rows), .cfg_row_bytes(cfg_row_bytes),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_nt(mem_req_nt), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .tf_tile(tf_tile), .tf_rd_row(tf_rd_row), .tf_rd_data(tf_rd_data),
    .tf_wr_en(tf_wr_en), .tf_wr_row(tf_wr_row), .tf_wr_data(tf_wr_data), .done(done)
  );

  // behavioural tile file and byte memory
  logic [511:0] tfm [8][16];
  logic [7:0]   mem [logic [31:0]];
  assign tf_rd_data = tfm[tf_tile][tf_rd_row];

  int n_chk = 0, n_fail = 0;
  int ph = 0, zrow = 0, req_cnt = 0, rsp_cnt = 0, rows_e = 0, len_e = 0, done_cnt = 0;
  int rsp_wait = 0;
  bit pend = 0, outstanding = 0, prev_stall = 0;
  logic [31:0] prev_addr, rsp_addr;
  logic [1:0]  t_op;
  int          t_tile, t_rows, t_len;
  logic [31:0] t_base, t_stride;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [7:0] mrd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [511:0] clip(logic [511:0] d, int len);
    logic [511:0] r = '0;
    for (int i = 0; i < 64; i++) if (i < len) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // reference model: phase 0 idle, 1 memory rows, 2 zero fill, 3 done due
  initial begin : engine
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (outstanding && rsp_wait == 0) begin
        mem_rsp_valid = 1'b1;
        for (int i = 0; i < 64; i++) mem_rsp_rdata[i*8 +: 8] = mrd(rsp_addr + 32'(i));
      end else begin
        mem_rsp_valid = 1'b0;
        if (outstanding) rsp_wait--;
      end
      mem_req_ready = !outstanding && (lf[0] | lf[1]);
      if (pend) begin
        cmd_valid = 1'b1; cmd_op = t_op; cmd_tile = 3'(t_tile);
        cmd_base = t_base; cmd_stride = t_stride;
        cfg_rows = 5'(t_rows); cfg_row_bytes = 7'(t_len);
      end else if (ph != 0) begin
        // junk command and configuration while busy (R1, R3)
        cmd_valid = 1'b1; cmd_op = lf[3:2]; cmd_tile = lf[6:4];
        cmd_base = {lf, lf}; cmd_stride = {lf[7:0], lf, lf[15:8]};
        cfg_rows = lf[8:4]; cfg_row_bytes = lf[14:8];
      end else begin
        cmd_valid = 1'b0;
      end
      #1;
      case (ph)
        0: begin
          chk(cmd_ready === 1'b1, "R1", "ready when idle", 512'(cmd_ready), 1);
          chk(done === 1'b0, "R8", "no done when idle", 512'(done), 0);
          chk(mem_req_valid === 1'b0, "R2", "no request when idle", 512'(mem_req_valid), 0);
          chk(tf_wr_en === 1'b0, "R4", "no tile write when idle", 512'(tf_wr_en), 0);
          if (cmd_valid) begin
            pend = 0; req_cnt = 0; rsp_cnt = 0;
            rows_e = (t_rows > 16) ? 16 : t_rows;
            len_e  = (t_len > 64) ? 64 : t_len;
            if (rows_e == 0) begin
              if (t_op[1]) ph = 3;
              else begin ph = 2; zrow = 0; end
            end else ph = 1;
          end
        end
        1: begin
          chk(cmd_ready === 1'b0, "R1", "busy during rows", 512'(cmd_ready), 0);
          chk(done === 1'b0, "R8", "no early done", 512'(done), 0);
          if (prev_stall)
            chk(mem_req_valid === 1'b1 && mem_req_addr === prev_addr, "R9", "stalled request held",
                512'(mem_req_addr), 512'(prev_addr));
          if (mem_req_valid) begin
            chk(!outstanding && req_cnt < rows_e, "R2", "single outstanding row", 512'(req_cnt), 512'(rows_e));
            if (mem_req_ready) begin
              logic [31:0] ea;
              ea = t_base + 32'(req_cnt) * t_stride;
              chk(mem_req_addr === ea, "R2", "row address", 512'(mem_req_addr), 512'(ea));
              chk(mem_req_len === 7'(len_e), "R3", "row length", 512'(mem_req_len), 512'(len_e));
              chk(mem_req_write === t_op[1], "R6", "direction", 512'(mem_req_write), 512'(t_op[1]));
              chk(mem_req_nt === (t_op == 2'd1), "R7", "streaming hint", 512'(mem_req_nt), 512'(t_op == 2'd1));
              if (t_op[1]) begin
                logic [511:0] ew;
                ew = clip(tfm[t_tile][req_cnt], len_e);
                chk(mem_req_wdata === ew, "R6", "store data", mem_req_wdata, ew);
                for (int i = 0; i < len_e; i++) mem[ea + 32'(i)] = ew[i*8 +: 8];
              end
              outstanding = 1; rsp_wait = int'(lf[5:4]) % 3; rsp_addr = ea; req_cnt++;
            end
          end
          if (mem_rsp_valid) begin
            outstanding = 0;
            if (!t_op[1]) begin
              logic [511:0] er;
              er = clip(mem_rsp_rdata, len_e);
              chk(tf_wr_en === 1'b1 && tf_wr_row === 4'(rsp_cnt) && tf_tile === 3'(t_tile),
                  "R4", "load row write", 512'({tf_wr_en, tf_wr_row}), 512'({1'b1, 4'(rsp_cnt)}));
              chk(tf_wr_data === er, "R4", "load row bytes", tf_wr_data, er);
              tfm[t_tile][rsp_cnt] = er;
            end else begin
              chk(tf_wr_en === 1'b0, "R6", "store leaves tile", 512'(tf_wr_en), 0);
            end
            rsp_cnt++;
            if (rsp_cnt == rows_e) begin
              zrow = rows_e;
              ph = (!t_op[1] && rows_e < 16) ? 2 : 3;
            end
          end else begin
            chk(tf_wr_en === 1'b0, "R4", "no write without response", 512'(tf_wr_en), 0);
          end
        end
        2: begin
          chk(cmd_ready === 1'b0, "R1", "busy during fill", 512'(cmd_ready), 0);
          chk(mem_req_valid === 1'b0, "R5", "no request in fill", 512'(mem_req_valid), 0);
          chk(tf_wr_en === 1'b1 && tf_wr_row === 4'(zrow) && tf_tile === 3'(t_tile),
              "R5", "fill row", 512'({tf_wr_en, tf_wr_row}), 512'({1'b1, 4'(zrow)}));
          chk(tf_wr_data === '0, "R5", "fill data", tf_wr_data, 0);
          tfm[t_tile][zrow] = '0;
          zrow++;
          if (zrow == 16) ph = 3;
        end
        default: begin
          chk(done === 1'b1, "R8", "done due", 512'(done), 1);
          chk(cmd_ready === 1'b0, "R1", "busy in done cycle", 512'(cmd_ready), 0);
          chk(tf_wr_en === 1'b0 && mem_req_valid === 1'b0, "R8", "quiet done cycle",
              512'({tf_wr_en, mem_req_valid}), 0);
          done_cnt++;
          ph = 0;
        end
      endcase
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
    end
  end

  task automatic run(input logic [1:0] op, input int tile, input logic [31:0] base,
                     input logic [31:0] stride, input int rows, input int len);
    int start;
    @(posedge clk);
    while (ph != 0 || pend) @(posedge clk);
    t_op = op; t_tile = tile; t_base = base; t_stride = stride; t_rows = rows; t_len = len;
    start = done_cnt;
    pend = 1;
    while (done_cnt == start) @(posedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not complete");
    summary();
    $finish;
  end

  initial begin : main
    for (int t = 0; t < 8; t++)
      for (int r = 0; r < 16; r++)
        tfm[t][r] = {16{32'(t * 32'h01010101 + r * 32'h00370011 + 32'hC0DE0000)}};
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_tile = '0; cmd_base = '0;
    cmd_stride = '0; cfg_rows = '0; cfg_row_bytes = '0; mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    repeat (3) @(negedge clk);
    // R10: idle outputs while reset is held
    chk(cmd_ready === 1'b1, "R10", "reset ready", 512'(cmd_ready), 1);
    chk(mem_req_valid === 1'b0, "R10", "reset request", 512'(mem_req_valid), 0);
    chk(tf_wr_en === 1'b0, "R10", "reset tile write", 512'(tf_wr_en), 0);
    chk(done === 1'b0, "R10", "reset done", 512'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready === 1'b1 && mem_req_valid === 1'b0, "R10", "idle after release",
        512'({cmd_ready, mem_req_valid}), 512'(2'b10));

    run(2'd0, 1, 32'h0000_1000, 32'd100, 4, 64);          // R4 R5 partial rows
    run(2'd1, 2, 32'h0000_2000, 32'h40, 16, 10);          // R7 streaming, narrow rows
    run(2'd2, 2, 32'h0000_8000, 32'h40, 16, 10);          // R6 store
    run(2'd0, 3, 32'h0000_8000, 32'h40, 16, 64);          // R6 read back
    run(2'd3, 1, 32'h0000_9000, 32'hFFFF_FFC0, 3, 64);    // R2 R7 falling addresses, op 3
    run(2'd0, 4, 32'h0000_0500, 32'd8, 0, 5);             // R5 zero-row load
    run(2'd2, 4, 32'h0000_0600, 32'd8, 0, 5);             // R8 zero-row store
    run(2'd1, 5, 32'h0000_3000, 32'd200, 25, 100);        // R3 clamping
    run(2'd0, 6, 32'hFFFF_FFF0, 32'd16, 5, 33);           // R2 address wrap
    run(2'd0, 7, 32'h0000_4000, 32'd3, 16, 1);            // R4 one byte, overlapping rows
    repeat (4) @(posedge clk);
    summary();
    $finish;
  end
endmodule